// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (Master/Slave)

This block turns a stereo pair of signed (two's complement) samples into a single serial data line. The line is framed by a bit clock and a frame clock. A 2-bit selector picks one of four framings: two right-aligned formats, one left-aligned format, and one I2S-compatible format. The receiver samples on the rising bit-clock edge, so every data change is made at a falling bit-clock edge. Each frame carries the left channel first and then the right channel, MSB first. Both samples are captured together at the start of the frame.

In master mode the block derives its clocks from the system clock `clk_i`, which runs at 256 times the frame rate. The bit clock is `clk_i` divided by 4, which gives 64 bit periods per frame. The frame clock has a 50% duty cycle. In slave mode the block follows a bit clock and frame clock supplied from outside. It oversamples them with `clk_i` through a two-stage synchronizer and advances one bit slot on each falling edge it detects.

While `awake_i` is low the data line is held low and the master clocks are stopped. After `awake_i` rises, the block sends a programmable number of all-zero frames before the first real samples go out.

Top module: `audio_ser_tx`

## Requirements
- R1: Format code 0 sends the top 16 sample bits in slots 16 to 31 of each 32-slot half. Format code 1 sends the top 20 sample bits in slots 12 to 31. In both, the MSB goes first in the lowest slot.
- R2: Format code 2 sends the top 20 sample bits in slots 0 to 19 of each half. Format code 3 sends them in slots 1 to 20, one slot after the half starts. The MSB goes first in both.
- R3: Every slot that does not carry a word bit is driven low.
- R4: In master mode, `bclk_o` is `clk_i` divided by 4: low for two cycles, then high for two. A frame lasts 64 bit periods. `fclk_o` is high for 128 cycles and low for 128 cycles, and it changes only on the `clk_i` edge where `bclk_o` falls.
- R5: The left half comes first in each frame. During the left half `fclk_o` is high for format codes 0, 1 and 2, and low for code 3.
- R6: In master mode, `sdata_o` changes only on the `clk_i` edge where `bclk_o` falls.
- R7: Both channel samples are captured when slot 0 of the left half begins. Input changes later in the frame do not affect that frame.
- R8: In slave mode, each falling edge of `ext_bclk_i` advances one slot. `sdata_o` takes the new bit at the third `clk_i` edge after that falling edge. A level change of `ext_fclk_i`, seen at a falling edge, starts a new half at slot 0. The first such change after wake-up aligns the block. `bclk_o` and `fclk_o` stay low in slave mode.
- R9: In slave mode, format codes 2 and 3 accept halves of 16 or 24 slots. Word bits that fall beyond the end of the half are dropped. Format codes 0 and 1 need 32-slot halves.
- R10: While `awake_i` is low, `sdata_o` is low from the first `clk_i` edge that samples it low, and `bclk_o` stays low. Master timing restarts at slot 0 of the left half after wake-up.
- R11: After `awake_i` rises, the first QUIET_FRAMES frames are all zero. Real samples start with the next frame.
- R12: During and right after reset, `sdata_o` and `bclk_o` are low, and `fclk_o` is low while `master_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 256x frame rate in master mode |
| rst_ni | input | 1 | Asynchronous active-low reset |
| awake_i | input | 1 | Low = powered down, data forced low |
| master_i | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| fmt_i | input | 2 | Framing code 0..3 |
| left_i | input | SAMPLE_W | Left channel sample, two's complement |
| right_i | input | SAMPLE_W | Right channel sample, two's complement |
| ext_bclk_i | input | 1 | External bit clock (slave mode) |
| ext_fclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| fclk_o | output | 1 | Generated frame clock (master mode) |
| sdata_o | output | 1 | Serial data |

## Verification
Assertions in the RTL check the following on every cycle:
- the data line stays low in any cycle after `awake_i` was sampled low;
- master-mode data and frame-clock changes occur only where the bit clock falls;
- every slave slot step traces back to a falling edge of the external bit clock, three samples earlier;
- the start-up zero counter never climbs while the block is awake.

Slot placement for each format, the frame clock polarity, sample capture at frame start, truncation of short slave halves and the exact count of zero frames can only be shown by the bench's scenarios. The bench compares master mode with a behavioural model on every clock and checks slave mode at each external rising edge.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;

  typedef enum logic [1:0] {
    FMT_LSB16 = 2'd0,
    FMT_LSB20 = 2'd1,
    FMT_MSB20 = 2'd2,
    FMT_I2S20 = 2'd3
  } frame_fmt_e;

  localparam int HALF_SLOTS = 32;

  // Frame clock level that marks the left half.
  function automatic logic left_is_high(frame_fmt_e f);
    return (f != FMT_I2S20);
  endfunction

  // Bit to place in a slot; al holds the sample left-aligned in 32 bits.
  function automatic logic pick_bit(frame_fmt_e f, logic [5:0] slot, logic [31:0] al);
    int w;
    int off;
    int j;
    w = (f == FMT_LSB16) ? 16 : 20;
    case (f)
      FMT_LSB16, FMT_LSB20: off = HALF_SLOTS - w;
      FMT_MSB20:            off = 0;
      default:              off = 1;
    endcase
    j = int'(slot) - off;
    if (j >= 0 && j < w) pick_bit = al[5'(31 - j)];
    else                 pick_bit = 1'b0;
  endfunction

endpackage

// File: rtl/sat_master_timing.sv
`timescale 1ns/1ps
module sat_master_timing #(
  parameter int BCLK_DIV    = 4,
  parameter int FRAME_SLOTS = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       left_hi_i,
  output logic       tick_o,
  output logic [5:0] slot_o,
  output logic       left_o,
  output logic       bclk_o,
  output logic       fclk_o
);
  localparam int PH_W = $clog2(BCLK_DIV);
  localparam int SL_W = $clog2(FRAME_SLOTS);
  localparam int CW   = PH_W + SL_W;
  localparam logic [CW-1:0] IDLE = {{SL_W{1'b1}}, {PH_W{1'b0}}};

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [SL_W-1:0] nxt_slot;
  logic            phase_end;

  always_comb begin
    phase_end = &cnt_q[PH_W-1:0];
    nxt_slot  = cnt_q[CW-1:PH_W] + 1'b1;
    cnt_d     = run_i ? cnt_q + 1'b1 : IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= IDLE;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = run_i & phase_end;
  assign slot_o = 6'(nxt_slot[SL_W-2:0]);
  assign left_o = ~nxt_slot[SL_W-1];
  assign bclk_o = cnt_q[PH_W-1];
  assign fclk_o = cnt_q[CW-1] ^ left_hi_i;

  // R4
  fclk_on_bclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && (fclk_o != $past(fclk_o)) |-> $fell(bclk_o));

endmodule

// File: rtl/sat_slave_timing.sv
`timescale 1ns/1ps
module sat_slave_timing (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       left_hi_i,
  input  logic       ext_bclk_i,
  input  logic       ext_fclk_i,
  output logic       tick_o,
  output logic [5:0] slot_o,
  output logic       left_o
);
  logic b1_q, b2_q, bd_q, f1_q, f2_q;
  logic flast_q, flast_d;
  logic lock_q, lock_d;
  logic [5:0] slot_q, slot_d, slot_inc;
  logic fall, chg;

  always_comb begin
    fall     = bd_q & ~b2_q;
    chg      = (f2_q != flast_q);
    slot_inc = (slot_q == 6'h3f) ? slot_q : slot_q + 6'd1;
    flast_d  = fall ? f2_q : flast_q;
    lock_d   = lock_q;
    slot_d   = slot_q;
    if (!run_i) begin
      lock_d = 1'b0;
      slot_d = '0;
    end else if (fall) begin
      if (chg) begin
        lock_d = 1'b1;
        slot_d = '0;
      end else begin
        slot_d = slot_inc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b1_q    <= 1'b0;
      b2_q    <= 1'b0;
      bd_q    <= 1'b0;
      f1_q    <= 1'b0;
      f2_q    <= 1'b0;
      flast_q <= 1'b0;
      lock_q  <= 1'b0;
      slot_q  <= '0;
    end else begin
      b1_q    <= ext_bclk_i;
      b2_q    <= b1_q;
      bd_q    <= b2_q;
      f1_q    <= ext_fclk_i;
      f2_q    <= f1_q;
      flast_q <= flast_d;
      lock_q  <= lock_d;
      slot_q  <= slot_d;
    end
  end

  assign tick_o = run_i & fall & (lock_q | chg);
  assign slot_o = chg ? 6'd0 : slot_inc;
  assign left_o = (f2_q == left_hi_i);

  // R8
  slave_step_from_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (!$past(ext_bclk_i, 2) && $past(ext_bclk_i, 3)));

endmodule

// File: rtl/sat_startup.sv
`timescale 1ns/1ps
module sat_startup #(
  parameter int QUIET_FRAMES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic frame_tick_i,
  output logic mute_o
);
  localparam int QW = (QUIET_FRAMES < 1) ? 1 : $clog2(QUIET_FRAMES + 1);
  localparam logic [QW-1:0] QINIT = QW'(QUIET_FRAMES);

  logic [QW-1:0] q_q, q_d;
  logic          mute_q, mute_d;

  always_comb begin
    q_d    = q_q;
    mute_d = mute_q;
    if (!run_i) begin
      q_d    = QINIT;
      mute_d = 1'b1;
    end else if (frame_tick_i) begin
      mute_d = (q_q != '0);
      if (q_q != '0) q_d = q_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= QINIT;
      mute_q <= 1'b1;
    end else begin
      q_q    <= q_d;
      mute_q <= mute_d;
    end
  end

  assign mute_o = frame_tick_i ? (q_q != '0) : mute_q;

  // R11
  quiet_no_climb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) |-> q_q <= $past(q_q));

  // R11
  unmute_needs_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mute_q |-> (q_q == '0));

endmodule

// File: rtl/audio_ser_tx.sv
`timescale 1ns/1ps
module audio_ser_tx
  import sat_pkg::*;
#(
  parameter int SAMPLE_W     = 24,
  parameter int QUIET_FRAMES = 4,
  parameter int BCLK_DIV     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                awake_i,
  input  logic                master_i,
  input  logic [1:0]          fmt_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                ext_bclk_i,
  input  logic                ext_fclk_i,
  output logic                bclk_o,
  output logic                fclk_o,
  output logic                sdata_o
);
  localparam int FRAME_SLOTS = 2 * HALF_SLOTS;

  frame_fmt_e fmt;
  logic left_hi, run_m, run_s;
  logic m_tick, m_left, m_bclk, m_fclk;
  logic s_tick, s_left;
  logic [5:0] m_slot, s_slot, slot;
  logic tick, left_half, frame_tick, mute;
  logic [SAMPLE_W-1:0] lq, rq, ln, rn, cur;
  logic [31:0] al;
  logic sd_q, sd_d;

  assign fmt     = frame_fmt_e'(fmt_i);
  assign left_hi = left_is_high(fmt);
  assign run_m   = awake_i & master_i;
  assign run_s   = awake_i & ~master_i;

  sat_master_timing #(.BCLK_DIV(BCLK_DIV), .FRAME_SLOTS(FRAME_SLOTS)) u_mtim (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_m), .left_hi_i(left_hi),
    .tick_o(m_tick), .slot_o(m_slot), .left_o(m_left),
    .bclk_o(m_bclk), .fclk_o(m_fclk));

  sat_slave_timing u_stim (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_s), .left_hi_i(left_hi),
    .ext_bclk_i(ext_bclk_i), .ext_fclk_i(ext_fclk_i),
    .tick_o(s_tick), .slot_o(s_slot), .left_o(s_left));

  always_comb begin
    tick       = master_i ? m_tick : s_tick;
    slot       = master_i ? m_slot : s_slot;
    left_half  = master_i ? m_left : s_left;
    frame_tick = tick & left_half & (slot == 6'd0);
  end

  sat_startup #(.QUIET_FRAMES(QUIET_FRAMES)) u_start (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(awake_i),
    .frame_tick_i(frame_tick), .mute_o(mute));

  // Sample hold, bypassed on the capture cycle so slot 0 sees the new word.
  always_comb begin
    ln  = frame_tick ? left_i  : lq;
    rn  = frame_tick ? right_i : rq;
    cur = left_half ? ln : rn;
    al  = 32'(cur) << (32 - SAMPLE_W);
    sd_d = sd_q;
    if (!awake_i)  sd_d = 1'b0;
    else if (tick) sd_d = pick_bit(fmt, slot, al) & ~mute;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lq <= '0;
      rq <= '0;
    end else if (frame_tick) begin
      lq <= left_i;
      rq <= right_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sd_q <= 1'b0;
    else         sd_q <= sd_d;
  end

  assign sdata_o = sd_q;
  assign bclk_o  = master_i & m_bclk;
  assign fclk_o  = master_i & m_fclk;

  // R10
  asleep_data_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(awake_i) |-> !sdata_o);

  // R6
  data_on_bclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && $past(master_i) && awake_i && $past(awake_i) &&
    (sdata_o != $past(sdata_o)) |-> $fell(bclk_o));

endmodule

// File: tb/tb_audio_ser_tx.sv
`timescale 1ns/1ps
module tb_audio_ser_tx;
  localparam int CLK_PERIOD = 10;
  localparam int QF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic awake = 1'b0;
  logic master = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [23:0] left = '0;
  logic [23:0] right = '0;
  logic ebclk = 1'b1;
  logic efclk = 1'b0;
  logic bclk_o, fclk_o, sdata_o;

  int checks = 0;
  int fails = 0;
  bit cmp_en = 1'b0;
  bit rnd_en = 1'b0;
  bit done = 1'b0;

  audio_ser_tx #(.SAMPLE_W(24), .QUIET_FRAMES(QF), .BCLK_DIV(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .awake_i(awake), .master_i(master), .fmt_i(fmt),
    .left_i(left), .right_i(right), .ext_bclk_i(ebclk), .ext_fclk_i(efclk),
    .bclk_o(bclk_o), .fclk_o(fclk_o), .sdata_o(sdata_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  // Half-frame image: slot s carries bit [31-s]; mask marks word slots.
  function automatic logic [31:0] half_img(int f, logic [23:0] smp, bit want_mask);
    int w;
    logic [31:0] word;
    w = (f == 0) ? 16 : 20;
    word = want_mask ? ((32'd1 << w) - 1) : (32'(smp) >> (24 - w));
    case (f)
      0, 1:    return word;
      2:       return word << (32 - w);
      default: return word << (31 - w);
    endcase
  endfunction

  function automatic int exp_bit(int f, int s, logic [23:0] smp);
    logic [31:0] h;
    if (s > 31) return 0;
    h = half_img(f, smp, 1'b0);
    return int'(h[31 - s]);
  endfunction

  // ---------------- master-mode reference model ----------------
  int ph = 252;
  int frames = 0;
  int code = 0;
  int q[$];

  task automatic push_frame(logic [23:0] l, logic [23:0] r, bit muted);
    for (int h = 0; h < 2; h++) begin
      logic [31:0] img, msk;
      img = half_img(int'(fmt), (h == 0) ? l : r, 1'b0);
      msk = half_img(int'(fmt), 24'd0, 1'b1);
      for (int s = 0; s < 32; s++) begin
        int b;
        b = muted ? 0 : int'(img[31 - s]);
        q.push_back(b + 2 * int'(!msk[31 - s]) + 4 * int'(muted));
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n || !awake || !master) begin
      ph = 252;
      code = 0;
      frames = 0;
      q.delete();
    end else if (ph % 4 == 3) begin
      ph = (ph + 1) % 256;
      if (ph == 0) begin
        frames++;
        push_frame(left, right, frames <= QF);
      end
      code = (q.size() > 0) ? q.pop_front() : 0;
    end else begin
      ph++;
    end
  end

  int prev_sd = 0;
  int prev_bclk = 0;
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      string tag;
      int ll;
      ll = (fmt != 2'd3) ? 1 : 0;
      if (code & 4)      tag = "R11";
      else if (code & 2) tag = "R3";
      else if (fmt < 2)  tag = "R1";
      else               tag = "R2";
      chk(tag, int'(sdata_o), code & 1);
      chk("R4", int'(bclk_o), ((ph % 4) >= 2) ? 1 : 0);
      chk("R5", int'(fclk_o), ((ph >= 128) ? 1 : 0) ^ ll);
      if (awake && master && int'(sdata_o) != prev_sd)
        chk("R6", prev_bclk * 2 + int'(bclk_o), 2);
    end
    prev_sd = int'(sdata_o);
    prev_bclk = int'(bclk_o);
  end

  // Free-running sample changes, not aligned to frames (R7 in master runs).
  initial begin
    forever begin
      wclk(37);
      if (rnd_en) begin
        left = 24'($urandom);
        right = 24'($urandom);
      end
    end
  end

  task automatic run_master(int f, int nframes);
    awake = 1'b0;
    wclk(2);
    fmt = 2'(f);
    master = 1'b1;
    wclk(2);
    cmp_en = 1'b1;
    awake = 1'b1;
    wclk(256 * nframes + 77);
    awake = 1'b0;
    for (int i = 0; i < 20; i++) begin
      wclk(1);
      chk("R10", int'(sdata_o), 0);
      chk("R10", int'(bclk_o), 0);
    end
    cmp_en = 1'b0;
    master = 1'b0;
    wclk(2);
  endtask

  task automatic run_slave(int f, int hs);
    logic ll;
    logic [23:0] cl, cr, nl, nr;
    awake = 1'b0;
    master = 1'b0;
    fmt = 2'(f);
    ll = (f != 3);
    efclk = ~ll;
    ebclk = 1'b1;
    wclk(4);
    awake = 1'b1;
    wclk(4);
    for (int i = 0; i < 3; i++) begin
      ebclk = 1'b0; wclk(8);
      ebclk = 1'b1; wclk(8);
    end
    cl = 24'($urandom); cr = 24'($urandom);
    nl = cl; nr = cr;
    left = cl; right = cr;
    for (int fr = 1; fr <= QF + 2; fr++) begin
      for (int h = 0; h < 2; h++) begin
        for (int s = 0; s < hs; s++) begin
          string tag;
          int ex;
          ebclk = 1'b0;
          if (s == 0) efclk = (h == 0) ? ll : ~ll;
          wclk(4);
          if (h == 0 && s == 4) begin
            left = ~cl; right = ~cr;
          end
          if (h == 1 && s == 2) begin
            nl = 24'($urandom); nr = 24'($urandom);
            left = nl; right = nr;
          end
          wclk(4);
          ebclk = 1'b1;
          wclk(4);
          ex = (fr <= QF) ? 0 : exp_bit(f, s, (h == 0) ? cl : cr);
          if (fr <= QF)            tag = "R11";
          else if (h == 0 && s > 4) tag = "R7";
          else if (hs < 32)         tag = "R9";
          else                      tag = "R8";
          chk(tag, int'(sdata_o), ex);
          if (s == 0) begin
            chk("R8", int'(bclk_o), 0);
            chk("R8", int'(fclk_o), 0);
          end
          wclk(4);
        end
      end
      cl = nl; cr = nr;
    end
    awake = 1'b0;
    wclk(4);
    chk("R10", int'(sdata_o), 0);
  endtask

  initial begin
    wclk(5);
    chk("R12", int'(sdata_o), 0);
    chk("R12", int'(bclk_o), 0);
    chk("R12", int'(fclk_o), 0);
    rst_n = 1'b1;
    wclk(3);
    chk("R12", int'(sdata_o), 0);
    chk("R12", int'(bclk_o), 0);
    chk("R12", int'(fclk_o), 0);
    rnd_en = 1'b1;
    for (int f = 0; f < 4; f++) run_master(f, QF + 3);
    rnd_en = 1'b0;
    run_slave(0, 32);
    run_slave(1, 32);
    run_slave(3, 24);
    run_slave(2, 16);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule